// File: doc/BRIEF.md
# Blank/Convert Controlled SAR Conversion Controller

This block is the digital core of an 8-bit successive-approximation converter. One active-low control line, `blank_conv_i`, runs it. Driving the line low starts a conversion. Driving it high blanks the result outputs, and a long enough high period re-arms the converter for the next start. The analog parts sit outside the block: the DAC, the comparator, the reference and the optional bipolar offset source.

During a conversion the block presents a trial code on `dac_code_o`. It reads back a single comparator decision, `cmp_hi_i`, which is 1 when the trial value lies above the input. It resolves one bit per step, most significant bit first.

When the conversion ends, the active-low ready flag `drdy_no` falls. After a fixed delay the result is driven on `data_o`, qualified by `data_oe_o`, which stands in for a three-state enable. `bipolar_i` selects the offset-binary range. The block samples it at each start and brings it out on `offset_en_o`, so the external comparison point can add half of full scale. All delays are counted in clock cycles.

Top module: `sar_bc_ctrl`

## Requirements
- R1: After reset, and in standby with `blank_conv_i` high, `drdy_no` is 1, `data_oe_o` is 0 and `data_o` is all zeros.
- R2: A falling edge on `blank_conv_i` starts a conversion while the block is armed. `drdy_no` falls exactly SYNC_STAGES+1+DATA_W*SETTLE_CYC clock edges after the input falls. During the conversion `drdy_no` stays 1 and `data_oe_o` stays 0.
- R3: Bits are resolved MSB first. Each trial bit is set, held for SETTLE_CYC cycles, and then cleared if `cmp_hi_i` is 1. In unipolar mode (`offset_en_o`=0) the result is the largest code not above the input: 0x00, 0xFF, 0xA5 and 0x01 for those inputs.
- R4: With `bipolar_i`=1 at the start, `offset_en_o` is 1 and the result is offset binary. The lowest input gives 0x00, zero gives 0x80, the top gives 0xFF, and an input one step below zero gives 0x7F.
- R5: The range mode is captured when a conversion starts. A change of `bipolar_i` during a conversion does not affect `offset_en_o` or the result.
- R6: `data_oe_o` rises exactly DRIVE_DLY_CYC cycles after `drdy_no` falls. `data_o` equals the result while `data_oe_o` is 1 and is all zeros otherwise.
- R7: After a conversion, a high level lasting RELEASE_CYC synchronized cycles raises `drdy_no` and drops `data_oe_o`, exactly SYNC_STAGES+RELEASE_CYC edges after the input rises. A shorter high pulse leaves the result driven, and the falling edge that follows it starts no conversion.
- R8: A high level during a conversion halts it with `drdy_no` and `data_oe_o` unchanged. If the high level is shorter than CLEAR_CYC cycles, returning low starts no conversion.
- R9: A high level of at least CLEAR_CYC synchronized cycles clears the converter, whether it occurs during a conversion or after one. The next falling edge then starts a full new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| blank_conv_i | input | 1 | Asynchronous control: low converts, high blanks |
| bipolar_i | input | 1 | Range select, 1 = bipolar offset binary |
| cmp_hi_i | input | 1 | Comparator: 1 when the trial value is above the input |
| dac_code_o | output | DATA_W | Trial code to the DAC |
| offset_en_o | output | 1 | Enables the bipolar offset at the comparison point |
| drdy_no | output | 1 | Data ready, active low |
| data_o | output | DATA_W | Result, zero while not enabled |
| data_oe_o | output | 1 | Result drive enable |

## Verification
The bench times the high pulses on both sides of each threshold. A pulse one cycle short of the release width must leave the result driven. A pulse one cycle short of the clear width must leave a halted converter dead. A design that counted these widths off by one would blank a valid result, or restart after a glitch.

The bench also checks the exact cycles at which the ready flag falls and the data drive turns on, which would catch an extra or a missing pipeline register. It uses the extreme and mid-scale codes in both ranges, which catch a misplaced offset or a wrong bit order. It flips the range input in the middle of a conversion, which would corrupt the result in a design that does not latch the mode at the start.

// File: rtl/sar_bc_pkg.sv
package sar_bc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,   // armed, blanked
    ST_CONV,   // resolving bits
    ST_DONE,   // result held, ready low
    ST_WAIT    // blanked, waiting for a clearing high level
  } ctrl_st_e;
endpackage

// File: rtl/sar_bc_sync.sv
module sar_bc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES:0]   shift_in;

  assign shift_in = {chain_q, d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= shift_in[STAGES-1:0];
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_bc_runlen.sv
module sar_bc_runlen #(
  parameter int unsigned MAX = 20,
  parameter int unsigned CW  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lvl_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX);

  logic [CW-1:0] cnt_q;

  // consecutive high cycles, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!lvl_i)          cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;

  a_r9_run_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_i |=> (cnt_o == '0));
endmodule

// File: rtl/sar_bc_core.sv
module sar_bc_core #(
  parameter int unsigned W      = 8,
  parameter int unsigned SETTLE = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         abort_i,
  input  logic         cmp_hi_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] code_o
);
  localparam int unsigned    SW       = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [SW-1:0]  ST_LAST  = SW'(SETTLE - 1);
  localparam logic [W-1:0]   MSB_MASK = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  code_q, mask_q, code_nxt;
  logic [SW-1:0] st_q;
  logic          busy_q, settle_end;

  assign settle_end = (st_q == ST_LAST);
  assign fin_o      = busy_q & settle_end & mask_q[0];

  // decide current bit, then place the next trial bit
  always_comb begin
    code_nxt = code_q;
    if (cmp_hi_i) code_nxt = code_nxt & ~mask_q;
    code_nxt = code_nxt | (mask_q >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
      st_q   <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      code_q <= MSB_MASK;
      mask_q <= MSB_MASK;
      st_q   <= '0;
      busy_q <= 1'b1;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (settle_end) begin
        st_q   <= '0;
        code_q <= code_nxt;
        mask_q <= mask_q >> 1;
        if (mask_q[0]) busy_q <= 1'b0;
      end else begin
        st_q <= st_q + SW'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign code_o = code_q;

  a_r3_single_trial_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> $onehot(mask_q));
  a_r3_trial_bit_set_lower_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (((code_q & mask_q) != '0) && ((code_q & (mask_q - W'(1))) == '0)));
endmodule

// File: rtl/sar_bc_ctrl.sv
module sar_bc_ctrl
  import sar_bc_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned SETTLE_CYC    = 4,
  parameter int unsigned DRIVE_DLY_CYC = 2,
  parameter int unsigned RELEASE_CYC   = 15,
  parameter int unsigned CLEAR_CYC     = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blank_conv_i,
  input  logic              bipolar_i,
  input  logic              cmp_hi_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              offset_en_o,
  output logic              drdy_no,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  // CLEAR_CYC is expected to be >= RELEASE_CYC
  localparam int unsigned   RUN_MAX  = (CLEAR_CYC > RELEASE_CYC) ? CLEAR_CYC : RELEASE_CYC;
  localparam int unsigned   CW       = $clog2(RUN_MAX + 1);
  localparam logic [CW-1:0] REL_LAST = CW'(RELEASE_CYC - 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLEAR_CYC - 1);
  localparam int unsigned   DW       = (DRIVE_DLY_CYC > 0) ? $clog2(DRIVE_DLY_CYC + 1) : 1;
  localparam logic [DW-1:0] DRV_END  = DW'(DRIVE_DLY_CYC);

  ctrl_st_e          st_q, st_d;
  logic              bc_s, bc_q, bc_fall;
  logic [CW-1:0]     hi_cnt;
  logic              release_hit, clear_hit;
  logic              core_start, core_abort, core_busy, core_fin;
  logic [DATA_W-1:0] core_code;
  logic [DW-1:0]     drv_q;
  logic              offset_q;

  sar_bc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (blank_conv_i),
    .q_o   (bc_s)
  );

  sar_bc_runlen #(.MAX(RUN_MAX), .CW(CW)) u_runlen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (bc_s),
    .cnt_o (hi_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bc_q <= 1'b1;
    else         bc_q <= bc_s;
  end

  assign bc_fall     = bc_q & ~bc_s;
  assign release_hit = bc_s && (hi_cnt >= REL_LAST);
  assign clear_hit   = bc_s && (hi_cnt >= CLR_LAST);

  assign core_start  = (st_q == ST_IDLE) && bc_fall;
  assign core_abort  = (st_q == ST_CONV) && bc_s;

  sar_bc_core #(.W(DATA_W), .SETTLE(SETTLE_CYC)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (core_start),
    .abort_i (core_abort),
    .cmp_hi_i(cmp_hi_i),
    .busy_o  (core_busy),
    .fin_o   (core_fin),
    .code_o  (core_code)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (bc_fall)     st_d = ST_CONV;
      ST_CONV: if (bc_s)        st_d = ST_WAIT;
               else if (core_fin) st_d = ST_DONE;
      ST_DONE: if (release_hit) st_d = ST_WAIT;
      ST_WAIT: if (clear_hit)   st_d = ST_IDLE;
      default:                  st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      drv_q    <= '0;
      offset_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (core_start) offset_q <= bipolar_i;
      if (st_q != ST_DONE)      drv_q <= '0;
      else if (drv_q != DRV_END) drv_q <= drv_q + DW'(1);
    end
  end

  assign drdy_no     = (st_q != ST_DONE);
  assign data_oe_o   = (st_q == ST_DONE) && (drv_q == DRV_END);
  assign data_o      = data_oe_o ? core_code : '0;
  assign dac_code_o  = core_code;
  assign offset_en_o = offset_q;

  a_r6_drive_only_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !drdy_no);
  a_r2_ready_only_after_last_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drdy_no) |-> $past(core_fin));
  a_r7_release_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_no) |-> $past(bc_s));
  a_r8_halt_keeps_outputs_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_CONV) && bc_s) |=> (drdy_no && !data_oe_o));
  a_r5_mode_stable_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_busy && $past(core_busy)) |-> $stable(offset_en_o));
endmodule

// File: tb/tb_sar_bc_ctrl.sv
module tb_sar_bc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W      = 8;
  localparam int SYNC   = 2;
  localparam int SETTLE = 4;
  localparam int DLY    = 2;
  localparam int REL    = 15;
  localparam int CLR    = 20;
  localparam int LAT    = SYNC + 1 + W * SETTLE;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bc = 1'b1;
  logic         bip = 1'b0;
  logic         cmp_hi;
  logic [W-1:0] dac_code, data;
  logic         offset_en, drdy_n, data_oe;
  int           vin = 0;
  int           n_checks = 0;
  int           n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // comparator model: trial above input, offset by half scale in bipolar range
  always_comb cmp_hi = offset_en ? ((int'(dac_code) - 128) > vin) : (int'(dac_code) > vin);

  sar_bc_ctrl #(
    .DATA_W(W), .SYNC_STAGES(SYNC), .SETTLE_CYC(SETTLE),
    .DRIVE_DLY_CYC(DLY), .RELEASE_CYC(REL), .CLEAR_CYC(CLR)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .blank_conv_i(bc), .bipolar_i(bip),
    .cmp_hi_i(cmp_hi), .dac_code_o(dac_code), .offset_en_o(offset_en),
    .drdy_no(drdy_n), .data_o(data), .data_oe_o(data_oe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive low and check the whole conversion sequence
  task automatic convert(input int v, input bit b, input int exp, input string req);
    vin = v;
    bip = b;
    bc  = 1'b0;
    step(LAT - 1);
    chk("R2", "drdy before end", int'(drdy_n), 1);
    chk("R2", "oe before end", int'(data_oe), 0);
    chk("R6", "data blanked in conv", int'(data), 0);
    step(1);
    chk("R2", "drdy at end", int'(drdy_n), 0);
    chk("R6", "oe right after ready", int'(data_oe), 0);
    step(DLY - 1);
    chk("R6", "oe one cycle early", int'(data_oe), 0);
    step(1);
    chk("R6", "oe after delay", int'(data_oe), 1);
    chk(req, "result", int'(data), exp);
    chk(req, "offset enable", int'(offset_en), int'(b));
  endtask

  // long high level: release timing, then cleared
  task automatic release_all(input string req);
    bc = 1'b1;
    step(SYNC + REL - 1);
    chk(req, "drdy before release", int'(drdy_n), 0);
    step(1);
    chk(req, "drdy released", int'(drdy_n), 1);
    chk(req, "oe released", int'(data_oe), 0);
    chk("R6", "data zero when off", int'(data), 0);
    step(CLR - REL + 2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    bc    = 1'b1;
    step(3);
    chk("R1", "drdy in reset", int'(drdy_n), 1);
    rst_n = 1'b1;
    step(5);
    chk("R1", "drdy standby", int'(drdy_n), 1);
    chk("R1", "oe standby", int'(data_oe), 0);
    chk("R1", "data standby", int'(data), 0);
  endtask

  task automatic t_unipolar;
    convert(8'h00, 1'b0, 8'h00, "R3"); release_all("R7");
    convert(8'hFF, 1'b0, 8'hFF, "R3"); release_all("R7");
    convert(8'hA5, 1'b0, 8'hA5, "R3"); release_all("R7");
    convert(8'h01, 1'b0, 8'h01, "R3"); release_all("R7");
  endtask

  task automatic t_bipolar;
    convert(-128, 1'b1, 8'h00, "R4"); release_all("R7");
    convert(0,    1'b1, 8'h80, "R4"); release_all("R7");
    convert(127,  1'b1, 8'hFF, "R4"); release_all("R7");
    convert(-1,   1'b1, 8'h7F, "R4"); release_all("R7");
  endtask

  task automatic t_mode_latch;
    vin = 8'h40;
    bip = 1'b0;
    bc  = 1'b0;
    step(SYNC + 1 + SETTLE + 1);
    bip = 1'b1;
    step(LAT - (SYNC + 1 + SETTLE + 1) + DLY);
    chk("R5", "result with mode flip", int'(data), 8'h40);
    chk("R5", "offset enable kept", int'(offset_en), 0);
    bip = 1'b0;
    release_all("R7");
  endtask

  task automatic t_short_blank_done;
    convert(8'h5A, 1'b0, 8'h5A, "R3");
    bc = 1'b1;
    step(REL - 1);
    bc = 1'b0;
    step(LAT + 10);
    chk("R7", "drdy after short pulse", int'(drdy_n), 0);
    chk("R7", "oe after short pulse", int'(data_oe), 1);
    chk("R7", "data after short pulse", int'(data), 8'h5A);
    release_all("R7");
  endtask

  task automatic t_abort;
    vin = 8'h33;
    bip = 1'b0;
    bc  = 1'b0;
    step(SYNC + 10);
    bc = 1'b1;
    step(CLR - 1);
    bc = 1'b0;
    step(LAT + 10);
    chk("R8", "drdy after halt", int'(drdy_n), 1);
    chk("R8", "oe after halt", int'(data_oe), 0);
    bc = 1'b1;
    step(CLR);
    convert(8'hC3, 1'b0, 8'hC3, "R9");
    release_all("R7");
    // long pulse mid-conversion restarts cleanly
    vin = 8'h11;
    bc  = 1'b0;
    step(SYNC + 12);
    bc = 1'b1;
    step(CLR);
    convert(8'h6E, 1'b0, 8'h6E, "R9");
    release_all("R7");
  endtask

  initial begin
    t_reset;
    t_unipolar;
    t_bipolar;
    t_mode_latch;
    t_short_blank_done;
    t_abort;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule